// File: doc/BRIEF.md
# Fixed-Message UART Byte Sequencer

This block feeds a short, fixed text message into an attached byte-wide UART transmitter. The transmitter takes a byte with a data-valid strobe and later returns a single-cycle done pulse. The sequencer walks through the message one character at a time. For each character it raises data-valid for exactly one clock, holds the byte steady while the frame is on the line, and waits for done before it presents the next character. After the last character it parks in an idle state until a start request arrives.

The serial bit timing belongs entirely to the transmitter. The sequencer reacts only to the done handshake, so a single build works with any baud divisor. Leaving reset launches one message at once. After that, each start pulse seen in idle launches one more.

Top module: `uart_msg_sender`

## Requirements
- R1: The characters of a message go out in the order FIRST_CHAR+k for k = 0 .. MSG_LEN-1. With the defaults this is 0x41, 0x42, 0x43. Each is sent as a frame with one low start bit, eight data bits LSB first and one high stop bit.
- R2: `tx_valid_o` is high for exactly one clock per character. A message produces exactly MSG_LEN valid pulses and exactly MSG_LEN frames, and no character is ever retransmitted.
- R3: The sequencer moves to the next character only on a `tx_done_i` pulse. While it waits, `tx_byte_o` stays constant and `tx_valid_o` stays low.
- R4: In the clock after the done pulse of the last character, `busy_o` is low and the block is idle. It sends nothing more until a start request arrives.
- R5: While reset is asserted, `tx_valid_o` is low and `busy_o` is high, because the block sits ready to issue the first character. Releasing reset starts a message beginning with the first character.
- R6: A high `start_i` seen in idle makes `busy_o` high in the next clock and launches exactly one message. A `start_i` seen while busy has no effect.
- R7: Asserting reset in the middle of a message abandons it. The message sent after release starts again from the first character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request one message; sampled only while idle |
| tx_done_i | input | 1 | One-cycle completion pulse from the transmitter |
| tx_valid_o | output | 1 | One-cycle data-valid strobe to the transmitter |
| tx_byte_o | output | 8 | Registered character presented to the transmitter |
| busy_o | output | 1 | High from a start or from reset release until the last done pulse |

## Verification
Several properties are checked on every clock: the strobe is never wider than one cycle, the byte register holds its value and the state holds while waiting for done, idle never coincides with a strobe, a start in idle raises busy, and the character index stays in range. Other properties only show up through the bench's transmitter and line decoder. These are the order of the characters as they appear on the serial line, the count of exactly three frames per request, the absence of any extra frame after a start issued while busy, and the restart from the first character after a reset in the middle of a message.

// File: rtl/ums_pkg.sv
package ums_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  function automatic int idx_width(input int len);
    return (len > 1) ? $clog2(len) : 1;
  endfunction

endpackage

// File: rtl/ums_rst_sync.sv
module ums_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ums_char_gen.sv
module ums_char_gen
  import ums_pkg::*;
#(
  parameter int          MSG_LEN    = 3,
  parameter logic [7:0]  FIRST_CHAR = 8'h41,
  localparam int         IDX_W      = idx_width(MSG_LEN)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       char_o
);

  logic [7:0] table_w [MSG_LEN];

  for (genvar g = 0; g < MSG_LEN; g++) begin : g_char
    assign table_w[g] = 8'(int'(FIRST_CHAR) + g);
  end

  always_comb begin
    char_o = '0;
    for (int k = 0; k < MSG_LEN; k++) begin
      if (int'(idx_i) == k) char_o = table_w[k];
    end
  end

endmodule

// File: rtl/ums_fsm.sv
module ums_fsm
  import ums_pkg::*;
#(
  parameter int  MSG_LEN = 3,
  localparam int IDX_W   = idx_width(MSG_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [7:0]       char_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic [7:0]       byte_o,
  output logic             busy_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_LEN - 1);

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             valid_q, valid_d;
  logic [7:0]       byte_q;
  logic             byte_en;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    byte_en = 1'b0;
    valid_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) st_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        byte_en = 1'b1;
        valid_d = 1'b1;
        st_d    = ST_WAIT;
      end
      ST_WAIT: begin
        if (done_i) begin
          if (idx_q == LAST_IDX) begin
            idx_d = '0;
            st_d  = ST_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = ST_ISSUE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_ISSUE;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (byte_en) byte_q <= char_i;
  end

  assign idx_o   = idx_q;
  assign valid_o = valid_q;
  assign byte_o  = byte_q;
  assign busy_o  = (st_q != ST_IDLE);

  // R2: the strobe never lasts longer than one clock
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R3: while waiting without done, the state, index and byte all hold
  a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !done_i) |=> (st_q == ST_WAIT && $stable(idx_q) && $stable(byte_q)));

  // R3: the byte does not change in the cycle that leaves the wait phase
  a_r3_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |=> $stable(byte_q));

  // R4: idle never carries a strobe
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !valid_q);

  // R6: a start seen in idle raises busy in the next clock
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_i) |=> busy_o);

  // R1: the character index stays inside the message
  a_r1_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < MSG_LEN);

endmodule

// File: rtl/uart_msg_sender.sv
module uart_msg_sender
  import ums_pkg::*;
#(
  parameter int         MSG_LEN    = 3,
  parameter logic [7:0] FIRST_CHAR = 8'h41,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       tx_done_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_byte_o,
  output logic       busy_o
);

  localparam int IDX_W = idx_width(MSG_LEN);

  logic             rst_sync_n;
  logic [IDX_W-1:0] idx_w;
  logic [7:0]       char_w;

  ums_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ums_char_gen #(.MSG_LEN(MSG_LEN), .FIRST_CHAR(FIRST_CHAR)) u_char_gen (
    .idx_i  (idx_w),
    .char_o (char_w)
  );

  ums_fsm #(.MSG_LEN(MSG_LEN)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .done_i  (tx_done_i),
    .char_i  (char_w),
    .idx_o   (idx_w),
    .valid_o (tx_valid_o),
    .byte_o  (tx_byte_o),
    .busy_o  (busy_o)
  );

endmodule

// File: tb/uart_msg_sender_bench.sv
module uart_msg_sender_bench;

  localparam int CPB     = 139;
  localparam int MSG_LEN = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       done;
  logic       valid;
  logic [7:0] tx_byte;
  logic       busy;

  int checks = 0;
  int errs   = 0;

  always #10 clk = ~clk;

  uart_msg_sender u_uart_msg_sender (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .tx_done_i  (done),
    .tx_valid_o (valid),
    .tx_byte_o  (tx_byte),
    .busy_o     (busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Transmitter model: start bit, 8 data bits LSB first, stop bit, then a one-cycle done
  int         m_phase;
  int         m_cnt;
  int         m_bit;
  logic [7:0] m_data;
  logic       ser;
  logic       m_busy;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_bit = 0;
      ser <= 1'b1; done <= 1'b0; m_busy <= 1'b0;
    end else begin
      done <= 1'b0;
      case (m_phase)
        0: begin
          ser <= 1'b1;
          if (valid) begin
            m_data = tx_byte; m_phase = 1; m_cnt = 0; m_bit = 0;
            m_busy <= 1'b1; ser <= 1'b0;
          end
        end
        1: begin
          ser <= 1'b0;
          m_cnt++;
          if (m_cnt == CPB) begin m_cnt = 0; m_phase = 2; ser <= m_data[0]; end
        end
        2: begin
          ser <= m_data[m_bit];
          m_cnt++;
          if (m_cnt == CPB) begin
            m_cnt = 0;
            if (m_bit == 7) begin m_phase = 3; ser <= 1'b1; end
            else begin m_bit++; ser <= m_data[m_bit]; end
          end
        end
        default: begin
          ser <= 1'b1;
          m_cnt++;
          if (m_cnt == CPB) begin
            m_cnt = 0; m_phase = 0; done <= 1'b1; m_busy <= 1'b0;
          end
        end
      endcase
    end
  end

  // Line decoder and per-cycle monitors, sampled away from the active edge
  int         r_state = 0;
  int         r_cnt = 0;
  int         r_bit = 0;
  logic [7:0] r_sh;
  logic [7:0] rx [0:63];
  int         rx_cnt = 0;
  int         vpulses = 0;
  logic       valid_prev = 1'b0;
  logic [7:0] held;

  always @(negedge clk) begin
    if (!rst_n) begin
      r_state = 0;
      valid_prev = 1'b0;
    end else begin
      if (valid) begin
        vpulses++;
        if (valid_prev) check(1'b0, "R2 strobe width", 2, 1);
        if (m_busy)     check(1'b0, "R2 strobe while transmitter busy", 1, 0);
        held = tx_byte;
      end else if (m_busy && tx_byte != held) begin
        check(1'b0, "R3 byte changed while waiting", tx_byte, held);
      end
      valid_prev = valid;
      case (r_state)
        0: if (!ser) begin r_state = 1; r_cnt = 0; end
        1: begin
          r_cnt++;
          if (r_cnt == CPB/2) begin
            if (ser) r_state = 0;
            else begin r_state = 2; r_cnt = 0; r_bit = 0; end
          end
        end
        2: begin
          r_cnt++;
          if (r_cnt == CPB) begin
            r_sh[r_bit] = ser; r_cnt = 0; r_bit++;
            if (r_bit == 8) r_state = 3;
          end
        end
        default: begin
          r_cnt++;
          if (r_cnt == CPB) begin
            check(ser == 1'b1, "R1 stop bit", ser, 1);
            if (rx_cnt < 64) rx[rx_cnt] = r_sh;
            rx_cnt++;
            r_state = 0;
          end
        end
      endcase
    end
  end

  task automatic wait_dones(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!done) @(negedge clk);
    end
  endtask

  task automatic check_message(input int base, input string tag);
    for (int k = 0; k < MSG_LEN; k++)
      check(rx[base+k] == 8'(8'h41 + k), tag, rx[base+k], 8'h41 + k);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    #4_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int base;
    int vbase;
    repeat (4) @(negedge clk);
    // R5: reset state
    check(valid == 1'b0, "R5 valid in reset", valid, 0);
    check(busy == 1'b1, "R5 busy in reset", busy, 1);
    rst_n = 1'b1;

    // R5/R1/R4: automatic message after reset release
    wait_dones(MSG_LEN);
    @(negedge clk);
    check(busy == 1'b0, "R4 busy after last done", busy, 0);
    check(valid == 1'b0, "R4 valid after last done", valid, 0);
    check(rx_cnt == MSG_LEN, "R2 frames after reset", rx_cnt, MSG_LEN);
    check(vpulses == MSG_LEN, "R2 strobes after reset", vpulses, MSG_LEN);
    check_message(0, "R1 order after reset");
    repeat (3000) @(negedge clk);
    check(rx_cnt == MSG_LEN, "R4 no frames while idle", rx_cnt, MSG_LEN);

    // R6: repeated start requests, idle gaps of different lengths
    for (int m = 0; m < 3; m++) begin
      base = rx_cnt; vbase = vpulses;
      repeat (m * 7 + 1) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy == 1'b1, "R6 busy after start", busy, 1);
      wait_dones(MSG_LEN);
      @(negedge clk);
      check(busy == 1'b0, "R4 idle after message", busy, 0);
      repeat (CPB) @(negedge clk);
      check(rx_cnt - base == MSG_LEN, "R6 frames per start", rx_cnt - base, MSG_LEN);
      check(vpulses - vbase == MSG_LEN, "R2 strobes per start", vpulses - vbase, MSG_LEN);
      check_message(base, "R1 order per start");
    end

    // R6: start while busy is ignored
    base = rx_cnt;
    pulse_start();
    wait_dones(1);
    pulse_start();
    wait_dones(MSG_LEN - 1);
    repeat (3000) @(negedge clk);
    check(rx_cnt - base == MSG_LEN, "R6 start while busy ignored", rx_cnt - base, MSG_LEN);
    check(busy == 1'b0, "R6 idle after ignored start", busy, 0);

    // R3: done withheld keeps the sequencer waiting with a stable byte
    base = rx_cnt;
    pulse_start();
    repeat (CPB * 5) @(negedge clk);
    check(busy == 1'b1 && tx_byte == 8'h41, "R3 waiting on first char", tx_byte, 8'h41);

    // R7: reset mid-message restarts from the first character
    wait_dones(1);
    repeat (CPB * 3) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R7 valid in reset", valid, 0);
    rst_n = 1'b1;
    base = rx_cnt;
    wait_dones(MSG_LEN);
    @(negedge clk);
    check(busy == 1'b0, "R7 idle after restart", busy, 0);
    repeat (CPB) @(negedge clk);
    check(rx_cnt - base == MSG_LEN, "R7 frames after restart", rx_cnt - base, MSG_LEN);
    check_message(base, "R7 order after restart");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule